// File: doc/BRIEF.md
# Slave Serial Configuration Sequencer

This block is the master side of a serial configuration link to a programmable target device. A single start request starts the whole load. It raises a power-enable output and waits a settling time. It then drives an active-low program pin low for a set time and releases it. Next it polls the target's ready (INIT) line until that line goes high. After that it takes the requested number of bytes from an upstream valid/ready stream and shifts each byte out on a data pin, most significant bit first, against a configuration clock that it generates. Last, it keeps pulsing the clock until the target's DONE line goes high.

All waits and clock phase widths are counted in system clock cycles and set by parameters. Each of the two polling loops has its own limit. When a limit runs out, the sequence stops and a failure flag is raised. The done flag and the failure flag never assert together. Each one holds until the next start request. If the upstream source flags a byte as bad, the data shifting stops and the block goes straight to the clock-until-DONE phase.

Top module: `slave_serial_loader`

## Requirements
- R1: While reset is asserted and after reset is released, the outputs are: power-enable low, program high, configuration clock low, data low, ready low, busy low, done low and fail low.
- R2: A start request seen while the block is not busy raises power-enable, which then stays high. The program pin falls after exactly PWR_WAIT_CYC cycles with power-enable high and program high.
- R3: The program pin stays low for exactly PROG_LOW_CYC cycles, then returns high. The configuration clock is never high while program is low.
- R4: After program is released, INIT is sampled once per cycle, for at most INIT_POLLS samples. A high value seen on the last allowed sample still continues the sequence. If no sample reads high, fail rises, the clock stays low and no data is sent.
- R5: Each byte is sent most significant bit first. Every clock pulse is high for exactly HALF_HI_CYC cycles. Each bit is on the data pin at least HALF_LO_CYC cycles before the rising edge of its clock pulse. The data pin never changes while the clock is high.
- R6: Exactly byte_count_i bytes are accepted and sent, using the value of byte_count_i captured at the start. Ready is high only while the block is waiting for the next byte. A count of zero sends no data.
- R7: If a byte is accepted with byte_err_i high, that byte is not sent. No further bytes are requested, and the block moves directly to the DONE phase.
- R8: After the data, DONE is sampled at the end of each clock-low phase. A further clock pulse is issued only while DONE reads low. When DONE reads high, done_o rises. The number of extra pulses equals the number issued before DONE was seen high.
- R9: If DONE has not read high after DONE_POLLS extra pulses, fail rises and no further pulse is issued.
- R10: done_o and fail_o never assert together. Each holds until the next start request, which clears it. A start request seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled when not busy |
| byte_count_i | input | CNT_W | Number of bytes to send, captured at start |
| byte_data_i | input | BYTE_W | Upstream byte |
| byte_valid_i | input | 1 | Upstream byte valid |
| byte_err_i | input | 1 | Upstream error flag, qualified by valid |
| byte_ready_o | output | 1 | Block is ready to take a byte |
| init_ready_i | input | 1 | Target ready-for-data line |
| cfg_done_i | input | 1 | Target configuration-done line |
| pwr_en_o | output | 1 | Target power enable |
| prog_n_o | output | 1 | Active-low program pin |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Serial configuration data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Load finished with DONE seen |
| fail_o | output | 1 | Load aborted on a timeout |

## Verification
The bench goes after the edges of each counted window. INIT going high on exactly the last permitted poll must still continue the sequence; a design with an off-by-one poll counter would fail instead. DONE that never rises must yield exactly DONE_POLLS extra pulses. A byte count of zero must skip the data phase. A byte flagged bad must not be shifted out; a design that got this wrong would shift it anyway or hang waiting for more bytes. The bench also rebuilds every shifted bit from the pin levels at each clock rise, so a design that sends bytes in the wrong bit order, or changes the data pin while the clock is high, shows up as a bit mismatch or a data-stability fault. A second start request in the middle of a load must not restart the load or change its byte count.

// File: rtl/ssl_pkg.sv
package ssl_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PWRUP,
    S_PROG,
    S_INITW,
    S_LOAD,
    S_SLO,
    S_SHI,
    S_FLO,
    S_FHI,
    S_OK,
    S_ERR
  } ssl_state_e;

  function automatic int unsigned ssl_max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ssl_rst_sync.sv
module ssl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ssl_timer.sv
module ssl_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = val_i;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ssl_poll_ctr.sv
module ssl_poll_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ssl_shifter.sv
module ssl_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [DW-1:0] data_i,
  output logic          next_bit_o,
  output logic          last_o
);
  localparam int IW = (DW > 1) ? $clog2(DW) : 1;

  logic [DW-1:0] sreg_q, sreg_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    sreg_d = sreg_q;
    idx_d  = idx_q;
    if (load_i) begin
      sreg_d = data_i;
      idx_d  = IW'(DW - 1);
    end else if (step_i) begin
      sreg_d = {sreg_q[DW-2:0], 1'b0};
      idx_d  = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      idx_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      idx_q  <= idx_d;
    end
  end

  assign next_bit_o = sreg_q[DW-2];
  assign last_o     = (idx_q == '0);
endmodule

// File: rtl/slave_serial_loader.sv
module slave_serial_loader #(
  parameter int PWR_WAIT_CYC = 5000000,
  parameter int PROG_LOW_CYC = 5000000,
  parameter int HALF_LO_CYC  = 2,
  parameter int HALF_HI_CYC  = 2,
  parameter int INIT_POLLS   = 100000,
  parameter int DONE_POLLS   = 100000,
  parameter int CNT_W        = 32,
  parameter int BYTE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  byte_count_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              byte_valid_i,
  input  logic              byte_err_i,
  output logic              byte_ready_o,
  input  logic              init_ready_i,
  input  logic              cfg_done_i,
  output logic              pwr_en_o,
  output logic              prog_n_o,
  output logic              cclk_o,
  output logic              din_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o
);
  import ssl_pkg::*;

  localparam int unsigned TMAX = ssl_max2(ssl_max2(PWR_WAIT_CYC, PROG_LOW_CYC),
                                          ssl_max2(HALF_LO_CYC, HALF_HI_CYC));
  localparam int TW = $clog2(TMAX + 1);
  localparam int PW = $clog2(ssl_max2(INIT_POLLS, DONE_POLLS) + 1);

  logic rst_s_n;

  ssl_state_e       st_q, st_d;
  logic             pwr_q, pwr_d, prog_q, prog_d, cclk_q, cclk_d, din_q, din_d;
  logic [CNT_W-1:0] left_q, left_d;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;
  logic          pc_clr, pc_inc;
  logic [PW-1:0] pcnt;
  logic          sh_load, sh_step, sh_next, sh_last;
  logic          left_load, left_dec;
  logic          idle_like;

  ssl_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  ssl_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  ssl_poll_ctr #(.W(PW)) u_poll (
    .clk(clk), .rst_n(rst_s_n), .clr_i(pc_clr), .inc_i(pc_inc), .cnt_o(pcnt)
  );

  ssl_shifter #(.DW(BYTE_W)) u_shf (
    .clk(clk), .rst_n(rst_s_n), .load_i(sh_load), .step_i(sh_step),
    .data_i(byte_data_i), .next_bit_o(sh_next), .last_o(sh_last)
  );

  assign idle_like = (st_q == S_IDLE) || (st_q == S_OK) || (st_q == S_ERR);

  // next-state and output decode
  always_comb begin
    st_d      = st_q;
    pwr_d     = pwr_q;
    prog_d    = prog_q;
    cclk_d    = cclk_q;
    din_d     = din_q;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    pc_clr    = 1'b0;
    pc_inc    = 1'b0;
    sh_load   = 1'b0;
    sh_step   = 1'b0;
    left_load = 1'b0;
    left_dec  = 1'b0;

    unique case (st_q)
      S_IDLE, S_OK, S_ERR: begin
        if (start_i) begin
          st_d      = S_PWRUP;
          pwr_d     = 1'b1;
          prog_d    = 1'b1;
          cclk_d    = 1'b0;
          din_d     = 1'b0;
          tmr_load  = 1'b1;
          tmr_val   = TW'(PWR_WAIT_CYC - 1);
          left_load = 1'b1;
        end
      end
      S_PWRUP: begin
        if (tmr_zero) begin
          st_d     = S_PROG;
          prog_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TW'(PROG_LOW_CYC - 1);
        end
      end
      S_PROG: begin
        if (tmr_zero) begin
          st_d   = S_INITW;
          prog_d = 1'b1;
          pc_clr = 1'b1;
        end
      end
      S_INITW: begin
        if (init_ready_i) begin
          if (left_q == '0) begin
            st_d     = S_FLO;
            tmr_load = 1'b1;
            tmr_val  = TW'(HALF_LO_CYC - 1);
            pc_clr   = 1'b1;
          end else begin
            st_d = S_LOAD;
          end
        end else if (pcnt == PW'(INIT_POLLS - 1)) begin
          st_d = S_ERR;
        end else begin
          pc_inc = 1'b1;
        end
      end
      S_LOAD: begin
        if (byte_valid_i) begin
          tmr_load = 1'b1;
          tmr_val  = TW'(HALF_LO_CYC - 1);
          if (byte_err_i) begin
            st_d   = S_FLO;
            din_d  = 1'b0;
            pc_clr = 1'b1;
          end else begin
            st_d    = S_SLO;
            sh_load = 1'b1;
            din_d   = byte_data_i[BYTE_W-1];
          end
        end
      end
      S_SLO: begin
        if (tmr_zero) begin
          st_d     = S_SHI;
          cclk_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = TW'(HALF_HI_CYC - 1);
        end
      end
      S_SHI: begin
        if (tmr_zero) begin
          cclk_d = 1'b0;
          if (sh_last) begin
            left_dec = 1'b1;
            if (left_q == CNT_W'(1)) begin
              st_d     = S_FLO;
              tmr_load = 1'b1;
              tmr_val  = TW'(HALF_LO_CYC - 1);
              pc_clr   = 1'b1;
            end else begin
              st_d = S_LOAD;
            end
          end else begin
            st_d     = S_SLO;
            sh_step  = 1'b1;
            din_d    = sh_next;
            tmr_load = 1'b1;
            tmr_val  = TW'(HALF_LO_CYC - 1);
          end
        end
      end
      S_FLO: begin
        if (tmr_zero) begin
          if (cfg_done_i) begin
            st_d = S_OK;
          end else if (pcnt == PW'(DONE_POLLS)) begin
            st_d = S_ERR;
          end else begin
            st_d     = S_FHI;
            cclk_d   = 1'b1;
            pc_inc   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = TW'(HALF_HI_CYC - 1);
          end
        end
      end
      S_FHI: begin
        if (tmr_zero) begin
          st_d     = S_FLO;
          cclk_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = TW'(HALF_LO_CYC - 1);
        end
      end
      default: st_d = S_IDLE;
    endcase

    left_d = left_q;
    if (left_load)     left_d = byte_count_i;
    else if (left_dec) left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= S_IDLE;
      pwr_q  <= 1'b0;
      prog_q <= 1'b1;
      cclk_q <= 1'b0;
      din_q  <= 1'b0;
      left_q <= '0;
    end else begin
      st_q   <= st_d;
      pwr_q  <= pwr_d;
      prog_q <= prog_d;
      cclk_q <= cclk_d;
      din_q  <= din_d;
      left_q <= left_d;
    end
  end

  assign pwr_en_o     = pwr_q;
  assign prog_n_o     = prog_q;
  assign cclk_o       = cclk_q;
  assign din_o        = din_q;
  assign byte_ready_o = (st_q == S_LOAD);
  assign busy_o       = !idle_like;
  assign done_o       = (st_q == S_OK);
  assign fail_o       = (st_q == S_ERR);
endmodule

// File: rtl/slave_serial_loader_chk.sv
module slave_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic byte_ready_o,
  input logic pwr_en_o,
  input logic prog_n_o,
  input logic cclk_o,
  input logic din_o,
  input logic busy_o,
  input logic done_o,
  input logic fail_o
);
  // R10: the two result flags are exclusive
  assert_excl_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R10: done holds until a start request
  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);

  // R9: fail holds until a start request
  assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !start_i) |=> fail_o);

  // R5: data pin steady while the clock is high
  assert_din_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o && $past(cclk_o)) |-> $stable(din_o));

  // R3: no clock pulse while program is low
  assert_no_clk_in_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> !cclk_o);

  // R6: a byte is requested only between pulses, during a busy load
  assert_ready_ctx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> (!cclk_o && busy_o && prog_n_o));

  // R2: power-enable never drops once raised
  assert_pwr_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_en_o |=> pwr_en_o);

  // R1: before power-up nothing toggles
  assert_quiet_unpowered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en_o |-> (prog_n_o && !cclk_o && !din_o));
endmodule

bind slave_serial_loader slave_serial_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_ready_o(byte_ready_o),
  .pwr_en_o(pwr_en_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
  .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
);

// File: tb/slave_serial_loader_tb_top.sv
module slave_serial_loader_tb_top;
  localparam int PWR  = 5;
  localparam int PROG = 4;
  localparam int HLO  = 2;
  localparam int HHI  = 3;
  localparam int IPL  = 20;
  localparam int DPL  = 10;
  localparam int CW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [CW-1:0] byte_count_i = '0;
  logic [7:0] byte_data_i = '0;
  logic byte_valid_i = 1'b0, byte_err_i = 1'b0;
  logic init_ready_i = 1'b0, cfg_done_i = 1'b0;
  logic byte_ready_o, pwr_en_o, prog_n_o, cclk_o, din_o, busy_o, done_o, fail_o;

  always #5 clk = ~clk;

  slave_serial_loader #(
    .PWR_WAIT_CYC(PWR), .PROG_LOW_CYC(PROG), .HALF_LO_CYC(HLO), .HALF_HI_CYC(HHI),
    .INIT_POLLS(IPL), .DONE_POLLS(DPL), .CNT_W(CW), .BYTE_W(8)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_count_i(byte_count_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_err_i(byte_err_i),
    .byte_ready_o(byte_ready_o), .init_ready_i(init_ready_i), .cfg_done_i(cfg_done_i),
    .pwr_en_o(pwr_en_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
    .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int run_id = 0;
  bit run_over = 1'b0;

  // monitor state, sampled at the falling clock edge
  int pulses = 0, hi_run = 0, bad_hi = 0, bad_din = 0;
  int pwr_cnt = 0, prog_cnt = 0, initp = 0;
  bit seen_low = 1'b0;
  logic prev_cclk = 1'b0, prev_din = 1'b0;
  logic capbits [256];

  always @(negedge clk) begin
    if (cclk_o && !prev_cclk) begin
      if (pulses < 256) capbits[pulses] = din_o;
      pulses = pulses + 1;
      hi_run = 1;
    end else if (cclk_o) begin
      hi_run = hi_run + 1;
    end
    if (!cclk_o && prev_cclk && hi_run != HHI) bad_hi = bad_hi + 1;
    if (cclk_o && prev_cclk && din_o != prev_din) bad_din = bad_din + 1;
    if (!prog_n_o) begin
      prog_cnt = prog_cnt + 1;
      seen_low = 1'b1;
    end
    if (pwr_en_o && prog_n_o && !seen_low) pwr_cnt = pwr_cnt + 1;
    if (seen_low && prog_n_o && !fail_o && !done_o && pulses == 0 && !init_ready_i)
      initp = initp + 1;
    prev_cclk = cclk_o;
    prev_din  = din_o;
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s run=%0d actual=%0d expected=%0d", tag, run_id, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input int r, input int i);
    return 8'((i * 59) + (r * 87) + 150);
  endfunction

  // n bytes, done after k extra pulses (k<0: never), error on byte err_at (<0: none),
  // init high after init_d polls-window cycles (<0: never)
  task automatic run(input int n, input int k, input int err_at, input int init_d,
                     input bit inject, input bit exp_fail, input int exp_pulses);
    int nb;
    nb = (err_at >= 0) ? err_at : n;
    run_id = run_id + 1;
    init_ready_i = 1'b0; cfg_done_i = 1'b0; byte_valid_i = 1'b0; byte_err_i = 1'b0;
    run_over = 1'b0;
    @(negedge clk); #1;
    pulses = 0; hi_run = 0; bad_hi = 0; bad_din = 0;
    pwr_cnt = 0; prog_cnt = 0; initp = 0; seen_low = 1'b0;
    byte_count_i = CW'(n);
    start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    chk(!done_o && !fail_o && busy_o, "R10 start clears flags", {done_o, fail_o, busy_o}, 3'b001);
    fork
      begin
        while (!(seen_low && prog_n_o) && !run_over) begin @(negedge clk); #1; end
        if (init_d >= 0 && !run_over) begin
          repeat (init_d) @(negedge clk);
          #1;
          init_ready_i = 1'b1;
        end
      end
      begin
        for (int i = 0; i < n; i++) begin
          while (!byte_ready_o && !run_over) begin @(negedge clk); #1; end
          if (run_over) break;
          byte_data_i  = byte_of(run_id, i);
          byte_err_i   = (i == err_at);
          byte_valid_i = 1'b1;
          @(negedge clk); #1;
          byte_valid_i = 1'b0;
          byte_err_i   = 1'b0;
          if (i == err_at) break;
          if (inject && i == 0) begin
            byte_count_i = CW'(7);
            start_i = 1'b1;
            @(negedge clk); #1;
            start_i = 1'b0;
          end
        end
      end
      begin
        if (k >= 0) begin
          while (pulses < 8 * nb + k && !run_over) begin @(negedge clk); #1; end
          cfg_done_i = 1'b1;
        end
      end
      begin
        while (!(done_o || fail_o)) begin @(negedge clk); #1; end
        run_over = 1'b1;
      end
    join
    if (exp_fail) chk(fail_o && !done_o, "R9/R4 fail flag", {done_o, fail_o}, 2'b01);
    else          chk(done_o && !fail_o, "R8 done flag", {done_o, fail_o}, 2'b10);
    chk(pulses == exp_pulses, "R6 pulse count", pulses, exp_pulses);
    chk(pwr_cnt == PWR, "R2 power wait", pwr_cnt, PWR);
    chk(prog_cnt == PROG, "R3 program low", prog_cnt, PROG);
    chk(bad_hi == 0, "R5 clock high width", bad_hi, 0);
    chk(bad_din == 0, "R5 data stable in high", bad_din, 0);
    if (pulses >= 8 * nb) begin
      int mism;
      mism = 0;
      for (int i = 0; i < nb; i++)
        for (int j = 0; j < 8; j++)
          if (capbits[8 * i + j] !== byte_of(run_id, i)[7 - j]) mism++;
      chk(mism == 0, "R5 msb-first bits", mism, 0);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk({pwr_en_o, prog_n_o, cclk_o, din_o, byte_ready_o, busy_o, done_o, fail_o} == 8'b01000000,
        "R1 in reset", {pwr_en_o, prog_n_o, cclk_o, din_o, byte_ready_o, busy_o, done_o, fail_o},
        8'b01000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({pwr_en_o, prog_n_o, cclk_o, din_o, byte_ready_o, busy_o, done_o, fail_o} == 8'b01000000,
        "R1 after reset", {pwr_en_o, prog_n_o, cclk_o, din_o, byte_ready_o, busy_o, done_o, fail_o},
        8'b01000000);

    // sweep of byte count and DONE delay (R6 covers count zero)
    for (int n = 0; n < 4; n++)
      for (int ki = 0; ki < 3; ki++) begin
        int k;
        k = (ki == 0) ? 0 : (ki == 1) ? 1 : 3;
        run(n, k, -1, 0, 1'b0, 1'b0, 8 * n + k);
      end

    // R7: upstream error on byte 2 of 4, then on the very first byte
    run(4, 2, 2, 1, 1'b0, 1'b0, 16 + 2);
    chk(pulses == 18, "R7 shifting stopped at bad byte", pulses, 18);
    run(3, 1, 0, 0, 1'b0, 1'b0, 1);
    chk(pulses == 1, "R7 bad first byte sends nothing", pulses, 1);

    // R10: start while busy is ignored (count stays 2)
    run(2, 1, -1, 0, 1'b1, 1'b0, 17);
    chk(prog_cnt == PROG, "R10 mid-run start ignored", prog_cnt, PROG);

    // R10: done holds
    repeat (20) @(negedge clk);
    chk(done_o && !fail_o, "R10 done holds", {done_o, fail_o}, 2'b10);

    // R4: INIT high on the last allowed poll
    run(1, 0, -1, IPL - 1, 1'b0, 1'b0, 8);

    // R4: INIT never high
    run(2, 0, -1, -1, 1'b0, 1'b1, 0);
    chk(initp == IPL, "R4 poll count before fail", initp, IPL);
    repeat (20) @(negedge clk);
    chk(fail_o && !done_o && !cclk_o, "R9 fail holds", {fail_o, done_o, cclk_o}, 3'b100);

    // R9: DONE never high
    run(1, -1, -1, 0, 1'b0, 1'b1, 8 + DPL);
    chk(pulses - 8 == DPL, "R9 extra pulses at timeout", pulses - 8, DPL);

    // R8: recovery run after a failure
    run(1, 2, -1, 3, 1'b0, 1'b0, 10);

    summary();
    $finish;
  end
endmodule